// File: doc/BRIEF.md
# Two-Bank Pin Controller with Change Interrupt

This block is a register-mapped general-purpose pin controller with one or two banks of pins. Each bank can be up to 32 pins wide. Each bank has an output-value register and a direction register. The direction register decides, pin by pin, whether the block drives the pin or only listens to it. Input pins pass through a multi-stage synchronizer before the block uses them. A bank raises a sticky status flag whenever any of its listening pins changes level, whether it rises or falls.

The status flags are combined with a per-bank enable mask and one global enable bit to form a single registered, level-sensitive interrupt line. Software reaches all state through a plain 32-bit bus with a word address, a write strobe, write data and combinational read data. A pending flag is cleared by writing a 1 to its position, so software can write back the value it read. Parameters set the bank width, whether the second bank exists, and the reset values of each bank's output and direction registers.

Top module: `gpio_twin`

## Requirements
- R1: After reset every direction bit of bank A is 1, so `pin_oe_a` is all zero and `pin_out_a` is zero. Bank B starts from its parameter defaults. The status, enable-mask and global-enable registers read zero, and `irq` is 0.
- R2: A direction bit of 1 makes its pin an input, with `pin_oe` at 0. A direction bit of 0 makes it an output, with `pin_oe` at 1. `pin_out` always equals the bank's output-value register.
- R3: Reading a bank's data word returns the synchronized pin level at input bits and the output register at output bits. Bits above the bank width read as zero.
- R4: The word address is the byte offset divided by four. Bank A data is at word 0 and bank A direction at word 1. Bank B data is at word 2 and bank B direction at word 3. Global enable is at word 0x47, status at word 0x48 and enable mask at word 0x4A. Bit 0 of the status and mask registers belongs to bank A and bit 1 to bank B. Any other address reads zero.
- R5: A status bit sets when any input-direction pin of its bank changes level, in either direction. Level changes seen on output-direction pins are ignored. A status bit stays set until it is cleared.
- R6: Writing the status word clears each bit written as 1 and leaves bits written as 0 unchanged. If a new change arrives in the same cycle as a clearing write, the bit stays 1.
- R7: `irq` is registered and rises one clock after a status bit is set while its mask bit and the global enable are 1. It is 0 whenever no bank has both status and mask set.
- R8: Only bit 31 of the global-enable word is stored, and the other bits read zero. `irq` can be 1 only while that bit was set in the previous cycle.
- R9: A pin level change becomes visible in the data read after two clock edges. The matching status bit sets on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in_a | input | CH_W | Bank A pin levels, asynchronous |
| pin_out_a | output | CH_W | Bank A output values |
| pin_oe_a | output | CH_W | Bank A output enables, 1 = drive |
| pin_in_b | input | CH_W | Bank B pin levels, asynchronous |
| pin_out_b | output | CH_W | Bank B output values, zero if single bank |
| pin_oe_b | output | CH_W | Bank B output enables, zero if single bank |
| irq | output | 1 | Level interrupt request |

## Verification
The checker watches several behaviours on every clock. It checks that a detected change always leaves its status bit set on the next edge, even against a clearing write, and that a status bit never drops without a clearing write. It also checks that a clearing write with no competing change does clear the bit, that `irq` never rises without the global enable or a masked pending flag, and that a direction write lands on the output enables. Other behaviours only the directed scenarios can show: the exact two-edge synchronizer latency, the mixed input/output readback with zeroed upper bits, the parameter reset values of bank B, and that level changes on output pins are ignored.

// File: rtl/gpio_twin_pkg.sv
package gpio_twin_pkg;
   localparam int unsigned BUS_W    = 32;
   localparam int unsigned NUM_BANK = 2;
   localparam int unsigned GIE_BIT  = 31;
   localparam int unsigned MIN_AW   = 7;
   // word addresses (byte offset / 4)
   localparam int unsigned WA_DATA_A = 'h00;
   localparam int unsigned WA_DIR_A  = 'h01;
   localparam int unsigned WA_DATA_B = 'h02;
   localparam int unsigned WA_DIR_B  = 'h03;
   localparam int unsigned WA_GIE    = 'h47;
   localparam int unsigned WA_STAT   = 'h48;
   localparam int unsigned WA_MASK   = 'h4A;
endpackage

// File: rtl/gpio_twin_sync.sv
module gpio_twin_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   localparam int unsigned DEPTH = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_twin_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
      end
   end

   assign q      = chain[STAGES-1];
   assign q_prev = chain[STAGES];
endmodule

// File: rtl/gpio_twin_port.sv
module gpio_twin_port #(
   parameter int unsigned W        = 32,
   parameter int unsigned STAGES   = 2,
   parameter logic [31:0] DOUT_RST = 32'h0,
   parameter logic [31:0] DIR_RST  = 32'hFFFF_FFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_data,
   input  logic         wr_dir,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe,
   output logic [W-1:0] rd_data,
   output logic [W-1:0] rd_dir,
   output logic         chg
);
   logic [W-1:0] out_q, dir_q, s_now, s_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= DOUT_RST[W-1:0];
         dir_q <= DIR_RST[W-1:0];
      end else begin
         if (wr_data) out_q <= wdata;
         if (wr_dir)  dir_q <= wdata;
      end
   end

   gpio_twin_sync #(.W(W), .STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(s_now), .q_prev(s_prev)
   );

   assign pin_out = out_q;
   assign pin_oe  = ~dir_q;
   assign rd_data = (s_now & dir_q) | (out_q & ~dir_q);
   assign rd_dir  = dir_q;
   assign chg     = |((s_now ^ s_prev) & dir_q);
endmodule

// File: rtl/gpio_twin_irq.sv
module gpio_twin_irq
   import gpio_twin_pkg::*;
#(
   parameter int unsigned NCH = NUM_BANK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   chg,
   input  logic             wr_gie,
   input  logic             wr_stat,
   input  logic             wr_mask,
   input  logic [BUS_W-1:0] wdata,
   output logic [NCH-1:0]   stat_q,
   output logic [NCH-1:0]   mask_q,
   output logic             gie_q,
   output logic             irq
);
   logic [NCH-1:0] clr;

   assign clr = wr_stat ? wdata[NCH-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
         gie_q  <= 1'b0;
         irq    <= 1'b0;
      end else begin
         stat_q <= (stat_q & ~clr) | chg;
         if (wr_mask) mask_q <= wdata[NCH-1:0];
         if (wr_gie)  gie_q  <= wdata[GIE_BIT];
         irq <= gie_q & (|(stat_q & mask_q));
      end
   end
endmodule

// File: rtl/gpio_twin.sv
module gpio_twin
   import gpio_twin_pkg::*;
#(
   parameter int unsigned CH_W       = 32,
   parameter bit          DUAL       = 1'b1,
   parameter int unsigned ADDR_W     = 7,
   parameter int unsigned SYNC_STAGE = 2,
   parameter logic [31:0] DOUT_DEF_A = 32'h0,
   parameter logic [31:0] DIR_DEF_A  = 32'hFFFF_FFFF,
   parameter logic [31:0] DOUT_DEF_B = 32'h0,
   parameter logic [31:0] DIR_DEF_B  = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [CH_W-1:0]   pin_in_a,
   output logic [CH_W-1:0]   pin_out_a,
   output logic [CH_W-1:0]   pin_oe_a,
   input  logic [CH_W-1:0]   pin_in_b,
   output logic [CH_W-1:0]   pin_out_b,
   output logic [CH_W-1:0]   pin_oe_b,
   output logic              irq
);
   if (CH_W < 1 || CH_W > BUS_W) begin : g_bad_width
      $error("gpio_twin: CH_W must be 1..32");
   end
   if (ADDR_W < MIN_AW) begin : g_bad_aw
      $error("gpio_twin: ADDR_W too small for the register map");
   end

   logic hit_da, hit_ra, hit_db, hit_rb, hit_gie, hit_stat, hit_mask;
   assign hit_da   = bus_addr == ADDR_W'(WA_DATA_A);
   assign hit_ra   = bus_addr == ADDR_W'(WA_DIR_A);
   assign hit_db   = bus_addr == ADDR_W'(WA_DATA_B);
   assign hit_rb   = bus_addr == ADDR_W'(WA_DIR_B);
   assign hit_gie  = bus_addr == ADDR_W'(WA_GIE);
   assign hit_stat = bus_addr == ADDR_W'(WA_STAT);
   assign hit_mask = bus_addr == ADDR_W'(WA_MASK);

   logic [CH_W-1:0]     rd_data_a, rd_dir_a, rd_data_b, rd_dir_b;
   logic [NUM_BANK-1:0] chg_vec, stat_q, mask_q;
   logic                gie_q;

   gpio_twin_port #(
      .W(CH_W), .STAGES(SYNC_STAGE), .DOUT_RST(DOUT_DEF_A), .DIR_RST(DIR_DEF_A)
   ) u_bank_a (
      .clk(clk), .rst_n(rst_n),
      .wr_data(bus_wr & hit_da), .wr_dir(bus_wr & hit_ra),
      .wdata(bus_wdata[CH_W-1:0]), .pin_in(pin_in_a),
      .pin_out(pin_out_a), .pin_oe(pin_oe_a),
      .rd_data(rd_data_a), .rd_dir(rd_dir_a), .chg(chg_vec[0])
   );

   if (DUAL) begin : g_bank_b
      gpio_twin_port #(
         .W(CH_W), .STAGES(SYNC_STAGE), .DOUT_RST(DOUT_DEF_B), .DIR_RST(DIR_DEF_B)
      ) u_bank_b (
         .clk(clk), .rst_n(rst_n),
         .wr_data(bus_wr & hit_db), .wr_dir(bus_wr & hit_rb),
         .wdata(bus_wdata[CH_W-1:0]), .pin_in(pin_in_b),
         .pin_out(pin_out_b), .pin_oe(pin_oe_b),
         .rd_data(rd_data_b), .rd_dir(rd_dir_b), .chg(chg_vec[1])
      );
   end else begin : g_no_bank_b
      logic unused_b;
      assign unused_b   = ^pin_in_b;
      assign pin_out_b  = '0;
      assign pin_oe_b   = '0;
      assign rd_data_b  = '0;
      assign rd_dir_b   = '0;
      assign chg_vec[1] = 1'b0;
   end

   gpio_twin_irq #(.NCH(NUM_BANK)) u_irq (
      .clk(clk), .rst_n(rst_n), .chg(chg_vec),
      .wr_gie(bus_wr & hit_gie), .wr_stat(bus_wr & hit_stat),
      .wr_mask(bus_wr & hit_mask), .wdata(bus_wdata),
      .stat_q(stat_q), .mask_q(mask_q), .gie_q(gie_q), .irq(irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (hit_da)   bus_rdata = BUS_W'(rd_data_a);
      if (hit_ra)   bus_rdata = BUS_W'(rd_dir_a);
      if (hit_db)   bus_rdata = BUS_W'(rd_data_b);
      if (hit_rb)   bus_rdata = BUS_W'(rd_dir_b);
      if (hit_gie)  bus_rdata[GIE_BIT] = gie_q;
      if (hit_stat) bus_rdata[NUM_BANK-1:0] = stat_q;
      if (hit_mask) bus_rdata[NUM_BANK-1:0] = mask_q;
   end
endmodule

// File: rtl/gpio_twin_chk.sv
module gpio_twin_chk
   import gpio_twin_pkg::*;
#(
   parameter int unsigned CH_W   = 32,
   parameter int unsigned ADDR_W = 7
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic [31:0]         bus_wdata,
   input logic [CH_W-1:0]     pin_oe_a,
   input logic                irq,
   input logic [NUM_BANK-1:0] chg_vec,
   input logic [NUM_BANK-1:0] stat_q,
   input logic [NUM_BANK-1:0] mask_q,
   input logic                gie_q
);
   logic wr_stat, wr_dir_a;
   assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(WA_STAT));
   assign wr_dir_a = bus_wr && (bus_addr == ADDR_W'(WA_DIR_A));

   // R2: a direction write reaches the output enables on the next edge
   a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir_a |=> (pin_oe_a == ~$past(bus_wdata[CH_W-1:0])));

   // R8: the request needs the global enable
   a_r8_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(gie_q));

   // R7: nothing pending and unmasked means no request next cycle
   a_r7_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(stat_q & mask_q)) |=> !irq);

   for (genvar c = 0; c < NUM_BANK; c++) begin : g_bank
      // R5, R6: a change always sets the flag, even against a clearing write
      a_r5_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
         chg_vec[c] |=> stat_q[c]);
      // R5: a flag is sticky without a clearing write
      a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_q[c] && !(wr_stat && bus_wdata[c])) |=> stat_q[c]);
      // R6: a clearing write with no competing change clears
      a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_stat && bus_wdata[c] && !chg_vec[c]) |=> !stat_q[c]);
   end
endmodule

bind gpio_twin gpio_twin_chk #(.CH_W(CH_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .pin_oe_a(pin_oe_a), .irq(irq),
   .chg_vec(chg_vec), .stat_q(stat_q), .mask_q(mask_q), .gie_q(gie_q)
);

// File: tb/sim_gpio_twin.sv
`timescale 1ns/1ps
module sim_gpio_twin;
   localparam int unsigned W  = 24;
   localparam int unsigned AW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [W-1:0]  pin_in_a = '0, pin_in_b = '0;
   logic [W-1:0]  pin_out_a, pin_oe_a, pin_out_b, pin_oe_b;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   gpio_twin #(
      .CH_W(W), .DUAL(1'b1), .ADDR_W(AW),
      .DOUT_DEF_B(32'h0000_00C3), .DIR_DEF_B(32'hFFFF_FF00)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in_a(pin_in_a), .pin_out_a(pin_out_a), .pin_oe_a(pin_oe_a),
      .pin_in_b(pin_in_b), .pin_out_b(pin_out_b), .pin_oe_b(pin_oe_b),
      .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input int unsigned a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int unsigned a, output logic [31:0] d);
      bus_addr = AW'(a);
      #1 d = bus_rdata;
   endtask

   task automatic settle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R1 oe_a", 32'(pin_oe_a), 32'h0);
      chk("R1 out_a", 32'(pin_out_a), 32'h0);
      chk("R1 oe_b default", 32'(pin_oe_b), 32'h0000_00FF);
      chk("R1 out_b default", 32'(pin_out_b), 32'h0000_00C3);
      chk("R1 irq", 32'(irq), 32'h0);
      rd('h01, v); chk("R1 dir_a read", v, 32'h00FF_FFFF);
      rd('h48, v); chk("R1 stat", v, 32'h0);
      rd('h4A, v); chk("R1 mask", v, 32'h0);
      rd('h47, v); chk("R1 gie", v, 32'h0);
   endtask

   task automatic t_outputs;
      logic [31:0] v;
      wr('h01, 32'h00FF_FF00);
      wr('h00, 32'h0012_3456);
      chk("R2 out_a", 32'(pin_out_a), 32'h0012_3456);
      chk("R2 oe_a", 32'(pin_oe_a), 32'h0000_00FF);
      pin_in_a = 24'hABCDEF;
      settle(3);
      rd('h00, v); chk("R3 mixed readback", v, 32'h00AB_CD56);
      wr('h02, 32'hFFFF_FF5A);
      chk("R4 out_b", 32'(pin_out_b), 32'h00FF_FF5A);
      wr('h03, 32'hFFFF_FFFF);
      rd('h03, v); chk("R3 dir_b upper zero", v, 32'h00FF_FFFF);
      chk("R4 oe_b", 32'(pin_oe_b), 32'h0);
      rd('h10, v); chk("R4 unmapped", v, 32'h0);
      wr('h48, 32'h3);
      rd('h48, v); chk("R6 cleared", v, 32'h0);
   endtask

   task automatic t_sync;
      logic [31:0] v;
      @(negedge clk);
      pin_in_a[8] = ~pin_in_a[8];
      @(negedge clk);
      rd('h00, v); chk("R9 one edge old", v, 32'h00AB_CD56);
      @(negedge clk);
      rd('h00, v); chk("R9 two edges new", v, 32'h00AB_CC56);
      rd('h48, v); chk("R9 stat not yet", v, 32'h0);
      @(negedge clk);
      rd('h48, v); chk("R9 R5 stat third edge", v, 32'h1);
   endtask

   task automatic t_irq;
      logic [31:0] v;
      wr('h4A, 32'h1);
      settle(1);
      chk("R8 no gie no irq", 32'(irq), 32'h0);
      wr('h47, 32'h8000_0000);
      chk("R7 irq not before gie reg", 32'(irq), 32'h0);
      settle(1);
      chk("R7 irq raised", 32'(irq), 32'h1);
      rd('h47, v); chk("R8 gie readback", v, 32'h8000_0000);
      wr('h47, 32'h7FFF_FFFF);
      rd('h47, v); chk("R8 other bits ignored", v, 32'h0);
      settle(1);
      chk("R8 irq off with gie", 32'(irq), 32'h0);
      wr('h47, 32'h8000_0000);
      wr('h4A, 32'h0);
      settle(1);
      chk("R7 masked", 32'(irq), 32'h0);
      wr('h4A, 32'h1);
      settle(1);
      chk("R7 unmasked", 32'(irq), 32'h1);
      wr('h48, 32'h1);
      settle(1);
      chk("R7 irq drops after clear", 32'(irq), 32'h0);
   endtask

   task automatic t_clear;
      logic [31:0] v;
      @(negedge clk);
      pin_in_a[9] = ~pin_in_a[9];
      settle(4);
      rd('h48, v); chk("R5 stat set", v, 32'h1);
      wr('h48, 32'h0);
      rd('h48, v); chk("R6 write zero keeps", v, 32'h1);
      pin_in_a[9] = ~pin_in_a[9];
      settle(2);
      bus_addr = AW'('h48); bus_wdata = 32'h1; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      rd('h48, v); chk("R6 set wins over clear", v, 32'h1);
      wr('h48, 32'h1);
      rd('h48, v); chk("R6 clear", v, 32'h0);
   endtask

   task automatic t_out_ignored;
      logic [31:0] v;
      @(negedge clk);
      pin_in_a[3] = ~pin_in_a[3];
      settle(4);
      rd('h48, v); chk("R5 output pin ignored", v, 32'h0);
   endtask

   task automatic t_bank_b;
      logic [31:0] v;
      @(negedge clk);
      pin_in_b[12] = 1'b1;
      settle(4);
      rd('h48, v); chk("R5 bank B rise", v, 32'h2);
      rd('h02, v); chk("R3 bank B pin read", v, 32'h0000_1000);
      wr('h48, 32'h2);
      pin_in_b[12] = 1'b0;
      settle(4);
      rd('h48, v); chk("R5 bank B fall", v, 32'h2);
      wr('h48, 32'h2);
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      settle(3);
      rst_n = 1'b1;
      settle(1);
      t_reset;
      t_outputs;
      t_sync;
      t_irq;
      t_clear;
      t_out_ignored;
      t_bank_b;
      settle(2);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule